// File: doc/BRIEF.md
# Coincidence Gate Timing Unit

This block decides, one event at a time, whether a detector pulse lines up in time with a pulse on an external gate line. Timing is counted in clock ticks. At a 40 MHz clock, one tick is 25 ns. The block takes three inputs:

- an asynchronous gate input, which is synchronized inside the block;
- a one-cycle trigger strobe from the fast channel;
- a one-cycle peak strobe that carries the measured amplitude.

For every peak strobe it returns one decision pulse. The pulse carries an accept bit and a route tag. The tag tells the histogram memory downstream whether to file the event as gated or ungated.

A trigger starts a search for a gate rising edge. An edge matches when it lies at a signed distance from the trigger, between a programmable offset and that offset plus a programmable window. A short record of recent gate edges lets an edge that came before the trigger still match. Once a match is found, an acceptance window opens after a programmable delay and stays open for a programmable width. A peak that arrives while that window is open counts as coincident.

There are four host-selected modes. Off accepts every event. Coincidence accepts only coincident events. Anticoincidence accepts only non-coincident events. Route accepts every event and tags each one, so the gated and ungated stores are filled together and their sum is the total spectrum.

Top module: `coinc_gate_unit`

## Requirements
- R1: A gate rising edge is dated to the clock edge two cycles after the first clock edge at which `gate_in` is sampled high. This is the two-flop synchronizer latency plus edge detection.
- R2: Let G be the dated gate edge and T the clock edge that samples `trig_strobe`. The edge matches when `cfg_offset <= G - T <= cfg_offset + cfg_window`. `cfg_offset` is an 8-bit two's complement tick count. `cfg_window` is an 8-bit unsigned tick count, so the upper bound can reach +382.
- R3: A gate edge that comes up to 128 ticks before the trigger can still match. The block keeps the most recent `HIST_DEPTH` gate edges for this.
- R4: Call the detection edge D. D is T when the matching gate edge is at or before T, and D is G otherwise. The window is open at clock edges D+delay+1 through D+delay+width. Delay and width are 13-bit unsigned tick counts.
- R5: A width of zero never opens the acceptance window.
- R6: Each peak strobe produces exactly one `evt_valid` pulse, registered on the same clock edge as the strobe. The pulse carries `peak_amp` on `evt_amp`. No pulse appears without a strobe.
- R7: In mode 2'b00 (off), every event is accepted and `evt_gated` is 0 unless the window is open.
- R8: In mode 2'b01 (coincidence), an event is accepted only when it is coincident.
- R9: In mode 2'b10 (anticoincidence), an event is accepted only when it is not coincident.
- R10: In mode 2'b11 (route), every event is accepted. `evt_gated` is 1 for coincident events and 0 for the rest.
- R11: Offset, window, delay and width are captured at the trigger. Changing them afterwards does not affect that trigger's search or window. `cfg_mode` is read at the peak strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_in | input | 1 | External gate, asynchronous |
| trig_strobe | input | 1 | Fast-channel trigger, one cycle |
| peak_strobe | input | 1 | Peak ready, one cycle |
| peak_amp | input | AMP_W | Amplitude that comes with the peak strobe |
| cfg_mode | input | 2 | 00 off, 01 coincidence, 10 anticoincidence, 11 route |
| cfg_offset | input | OFS_W | Signed coincidence offset in ticks |
| cfg_window | input | OFS_W | Coincidence window in ticks |
| cfg_delay | input | TIME_W | Delay from detection to window opening |
| cfg_width | input | TIME_W | Open duration of the acceptance window |
| evt_valid | output | 1 | Decision pulse |
| evt_accept | output | 1 | Event is to be stored |
| evt_gated | output | 1 | Route tag: event was coincident |
| evt_amp | output | AMP_W | Amplitude of the decided event |

## Verification
The bench aims at the exact edges of the match range:

- offset −128 with window 0, and one tick beyond it;
- the +382 upper limit, and a gate edge one tick short of the offset;
- the first and last open cycle of the acceptance window, and the cycle on either side of each.

A design with an extra or missing synchronizer stage would move every match by a tick. A design that dropped the edge record would miss gate edges that come before the trigger. An off-by-one in the window counter would accept a peak one cycle early or reject one on the last cycle. Further cases cover a zero width, a maximum delay, and a configuration changed mid-window. Each would show up as a wrong accept or tag bit on the decision pulse.

// File: rtl/coinc_gate_unit.sv
module coinc_gate_unit #(
  parameter int AMP_W      = 16,
  parameter int OFS_W      = 8,
  parameter int TIME_W     = 13,
  parameter int HIST_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gate_in,
  input  logic                    trig_strobe,
  input  logic                    peak_strobe,
  input  logic [AMP_W-1:0]        peak_amp,
  input  logic [1:0]              cfg_mode,
  input  logic signed [OFS_W-1:0] cfg_offset,
  input  logic [OFS_W-1:0]        cfg_window,
  input  logic [TIME_W-1:0]       cfg_delay,
  input  logic [TIME_W-1:0]       cfg_width,
  output logic                    evt_valid,
  output logic                    evt_accept,
  output logic                    evt_gated,
  output logic [AMP_W-1:0]        evt_amp
);

  localparam int SPAN_W = OFS_W + 2;
  localparam int AGE_W  = TIME_W + 2;
  localparam logic [OFS_W-1:0] HAGE_SAT = '1;

  // gate synchronizer and rising-edge detect (R1)
  logic [2:0] gsr;
  logic       rise;
  always_ff @(posedge clk) begin
    if (!rst_n) gsr <= '0;
    else        gsr <= {gsr[1:0], gate_in};
  end
  assign rise = gsr[1] & ~gsr[2];

  // ages of recent gate edges, saturating (R3)
  logic [OFS_W-1:0] hage [HIST_DEPTH];
  always_ff @(posedge clk) begin
    for (int i = 0; i < HIST_DEPTH; i++) begin
      if (!rst_n)
        hage[i] <= HAGE_SAT;
      else if (rise)
        hage[i] <= (i == 0) ? OFS_W'(1)
                 : (hage[(i == 0) ? 0 : i-1] == HAGE_SAT ? HAGE_SAT : hage[(i == 0) ? 0 : i-1] + 1'b1);
      else if (hage[i] != HAGE_SAT)
        hage[i] <= hage[i] + 1'b1;
    end
  end

  // live span from the configuration, used on the trigger edge (R2)
  logic signed [SPAN_W-1:0] live_lo, live_hi;
  assign live_lo = SPAN_W'(cfg_offset);
  assign live_hi = live_lo + $signed({2'b00, cfg_window});

  logic hist_hit;
  always_comb begin
    hist_hit = 1'b0;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      if (-$signed({2'b00, hage[i]}) >= live_lo && -$signed({2'b00, hage[i]}) <= live_hi)
        hist_hit = 1'b1;
    end
  end

  logic trig_hit;
  assign trig_hit = hist_hit | (rise && live_lo <= 0 && live_hi >= 0);

  // settings captured at the trigger (R11)
  logic signed [SPAN_W-1:0] s_lo, s_hi;
  logic [TIME_W-1:0]        s_dly, s_wid;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_lo  <= '0;
      s_hi  <= '0;
      s_dly <= '0;
      s_wid <= '0;
    end else if (trig_strobe) begin
      s_lo  <= live_lo;
      s_hi  <= live_hi;
      s_dly <= cfg_delay;
      s_wid <= cfg_width;
    end
  end

  // forward search for a gate edge after the trigger
  logic              pending;
  logic [SPAN_W-1:0] tage;
  logic              pend_hit;
  assign pend_hit = pending && rise && $signed(tage) >= s_lo && $signed(tage) <= s_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      tage    <= '0;
    end else if (trig_strobe) begin
      pending <= !trig_hit && live_hi > 0;
      tage    <= SPAN_W'(1);
    end else if (pending) begin
      if (pend_hit || $signed(tage) >= s_hi) pending <= 1'b0;
      else                                   tage    <= tage + 1'b1;
    end
  end

  logic detect;
  assign detect = trig_strobe ? trig_hit : pend_hit;

  // acceptance window (R4, R5)
  logic             active;
  logic [AGE_W-1:0] age;
  logic [AGE_W-1:0] win_end;
  logic             acc_open;
  assign win_end  = AGE_W'(s_dly) + AGE_W'(s_wid);
  assign acc_open = active && age > AGE_W'(s_dly) && age <= win_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      age    <= '0;
    end else if (detect) begin
      active <= 1'b1;
      age    <= AGE_W'(1);
    end else if (trig_strobe) begin
      active <= 1'b0;
    end else if (active) begin
      if (age >= win_end) active <= 1'b0;
      else                age    <= age + 1'b1;
    end
  end

  // decision pulse (R6..R10)
  logic accept_now;
  always_comb begin
    case (cfg_mode)
      2'b01:   accept_now = acc_open;
      2'b10:   accept_now = !acc_open;
      default: accept_now = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid  <= 1'b0;
      evt_accept <= 1'b0;
      evt_gated  <= 1'b0;
      evt_amp    <= '0;
    end else begin
      evt_valid  <= peak_strobe;
      evt_accept <= peak_strobe && accept_now;
      evt_gated  <= peak_strobe && acc_open;
      if (peak_strobe) evt_amp <= peak_amp;
    end
  end

endmodule

// File: rtl/coinc_gate_unit_chk.sv
module coinc_gate_unit_chk #(
  parameter int TIME_W = 13,
  parameter int AGE_W  = TIME_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              peak_strobe,
  input logic [1:0]        cfg_mode,
  input logic              evt_valid,
  input logic              evt_accept,
  input logic              evt_gated,
  input logic              acc_open,
  input logic [AGE_W-1:0]  age,
  input logic [TIME_W-1:0] s_dly,
  input logic [TIME_W-1:0] s_wid
);

  assert_one_decision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peak_strobe |=> evt_valid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_strobe |=> !evt_valid);

  assert_off_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_strobe && cfg_mode == 2'b00) |=> evt_accept);

  assert_coinc_follows_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_strobe && cfg_mode == 2'b01) |=> (evt_accept == evt_gated));

  assert_anti_inverts_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_strobe && cfg_mode == 2'b10) |=> (evt_accept != evt_gated));

  assert_route_keeps_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_strobe && cfg_mode == 2'b11) |=> evt_accept);

  assert_zero_width_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_open |-> (s_wid != '0));

  assert_open_after_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_open) |-> (age == {2'b00, s_dly} + AGE_W'(1)));

endmodule

bind coinc_gate_unit coinc_gate_unit_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .peak_strobe(peak_strobe), .cfg_mode(cfg_mode),
  .evt_valid(evt_valid), .evt_accept(evt_accept), .evt_gated(evt_gated),
  .acc_open(acc_open), .age(age), .s_dly(s_dly), .s_wid(s_wid)
);

// File: tb/coinc_gate_unit_test.sv
`timescale 1ns/1ps
module coinc_gate_unit_test;
  localparam int NOG = 9999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_in = 1'b0, trig_strobe = 1'b0, peak_strobe = 1'b0;
  logic [15:0] peak_amp = '0;
  logic [1:0]  cfg_mode = 2'b00;
  logic signed [7:0] cfg_offset = '0;
  logic [7:0]  cfg_window = '0;
  logic [12:0] cfg_delay = '0, cfg_width = '0;
  logic evt_valid, evt_accept, evt_gated;
  logic [15:0] evt_amp;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coinc_gate_unit uut (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .trig_strobe(trig_strobe),
    .peak_strobe(peak_strobe), .peak_amp(peak_amp), .cfg_mode(cfg_mode),
    .cfg_offset(cfg_offset), .cfg_window(cfg_window), .cfg_delay(cfg_delay),
    .cfg_width(cfg_width), .evt_valid(evt_valid), .evt_accept(evt_accept),
    .evt_gated(evt_gated), .evt_amp(evt_amp)
  );

  function automatic bit exp_open(int off, int win, int dly, int wid, int grel, int prel);
    int d;
    if (grel == NOG || grel < off || grel > off + win) return 1'b0;
    d = (grel <= 0) ? 0 : grel;
    return (prel > d + dly) && (prel <= d + dly + wid);
  endfunction

  function automatic bit exp_accept(logic [1:0] md, bit op);
    case (md)
      2'b01:   return op;
      2'b10:   return !op;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic run_evt(string tag, logic [1:0] md, int off, int win, int dly, int wid,
                         int grel, int prel, bit chg);
    int t, e0, p, idle, n;
    logic [15:0] amp;
    bit op;
    amp = 16'($urandom);
    @(negedge clk);
    cfg_mode = md; cfg_offset = 8'(off); cfg_window = 8'(win);
    cfg_delay = 13'(dly); cfg_width = 13'(wid);
    t = cyc + 150;
    e0 = t + grel - 2;
    p = t + prel;
    idle = 400 + dly + wid;
    op = exp_open(off, win, dly, wid, grel, prel);
    for (;;) begin
      n = cyc + 1;
      gate_in = (grel != NOG) && n >= e0 && n < e0 + 3;
      trig_strobe = (n == t);
      peak_strobe = (n == p);
      peak_amp = (n == p) ? amp : 16'h0;
      if (chg && n > t) begin
        cfg_delay = 13'(dly + 37); cfg_width = '0;
        cfg_offset = 8'(off - 5); cfg_window = '0;
      end
      @(negedge clk);
      if (cyc == p) begin
        check(tag, "evt_valid", evt_valid, 1);
        check(tag, "evt_gated", evt_gated, op);
        check(tag, "evt_accept", evt_accept, exp_accept(md, op));
        check("R6", "evt_amp", evt_amp, amp);
      end
      if (cyc == p + 1) check("R6", "evt_valid after pulse", evt_valid, 0);
      if (cyc >= p + idle) break;
    end
  endtask

  initial begin
    #(4 * 190000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R6", "evt_valid in reset", evt_valid, 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    check("R6", "evt_valid idle", evt_valid, 0);

    run_evt("R7",  2'b00, 0, 10, 3, 10, NOG, 12, 0);
    run_evt("R7",  2'b00, 0, 10, 3, 10, 5,   12, 0);
    run_evt("R8",  2'b01, 0, 10, 3, 10, 5,   12, 0);
    run_evt("R8",  2'b01, 0, 10, 3, 10, 11,  20, 0);
    run_evt("R9",  2'b10, 0, 10, 3, 10, 5,   12, 0);
    run_evt("R9",  2'b10, 0, 10, 3, 10, NOG, 12, 0);
    run_evt("R10", 2'b11, 0, 10, 3, 10, 5,   12, 0);
    run_evt("R10", 2'b11, 0, 10, 3, 10, NOG, 12, 0);
    run_evt("R3",  2'b01, -20, 10, 0, 5, -15, 3, 0);
    run_evt("R3",  2'b01, -128, 0, 0, 4, -128, 1, 0);
    run_evt("R3",  2'b01, -128, 0, 0, 4, -129, 1, 0);
    run_evt("R2",  2'b01, 127, 255, 0, 3, 382, 383, 0);
    run_evt("R2",  2'b01, 127, 255, 0, 3, 126, 200, 0);
    run_evt("R1",  2'b01, 2, 0, 0, 3, 2, 3, 0);
    run_evt("R1",  2'b01, -3, 0, 0, 3, -3, 1, 0);
    run_evt("R4",  2'b01, 0, 0, 4, 3, 0, 4, 0);
    run_evt("R4",  2'b01, 0, 0, 4, 3, 0, 5, 0);
    run_evt("R4",  2'b01, 0, 0, 4, 3, 0, 7, 0);
    run_evt("R4",  2'b01, 0, 0, 4, 3, 0, 8, 0);
    run_evt("R5",  2'b01, 0, 0, 0, 0, 0, 1, 0);
    run_evt("R11", 2'b01, 10, 20, 6, 8, 15, 25, 1);
    run_evt("R4",  2'b01, 0, 0, 8191, 2, 0, 8192, 0);

    for (int k = 0; k < 40; k++) begin
      int off, win, dly, wid, grel, prel;
      logic [1:0] md;
      md   = 2'($urandom_range(3, 0));
      off  = $urandom_range(40, 0) - 20;
      win  = $urandom_range(20, 0);
      dly  = $urandom_range(30, 0);
      wid  = $urandom_range(30, 0);
      grel = ($urandom_range(5, 0) == 0) ? NOG : $urandom_range(70, 0) - 30;
      prel = $urandom_range(80, 1);
      run_evt(md == 2'b00 ? "R7" : md == 2'b01 ? "R8" : md == 2'b10 ? "R9" : "R10",
              md, off, win, dly, wid, grel, prel, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule